// File: doc/BRIEF.md
# I2S to Dual-Channel Simultaneous Converter

This block takes a stereo I2S stream (bit clock, word select, serial data) and splits it into two independent serial channels for a converter that loads both channels in parallel. Each channel gets its own gated burst clock, its own data line and its own latch strobe. On the way through, every sample is turned from two's complement into offset binary by flipping only its most significant bit.

The three I2S pins are oversampled by a fast system clock, at least eight times the bit clock, and every output comes straight from a register, so decode transitions never show as glitches on the outputs. The channel that owns a bit is taken from word select as it stood one bit period earlier, because word select leads the MSB of a word by one bit. Bit slots past the configured word length are dropped, so bit clock rates from 32 to 64 times the sample rate are accepted.

Top module: `i2s_simul_split`

## Requirements
- R1: Each channel delivers its sample in offset binary: the bit stream presented for a word equals the received two's-complement word with bit WORD_W-1 (the MSB, sent first) inverted and all other bits unchanged, MSB first.
- R2: The first BCK rising edge after a WS change still carries the last bit of the previous word; the MSB of the new word is the bit on the second rising edge.
- R3: WS low selects the left channel, WS high the right one. Each forwarded bit produces one pulse on the owning channel's clock output only; the other channel's clock stays low, and both are never high together.
- R4: A channel's latch strobe rises on the BCK falling edge that follows the slot carrying bit index WORD_W-1 of that channel's word, stays high for exactly one BCK period, and is low whenever that channel's clock is high.
- R5: A channel's data output does not change while its clock output is high, and each clock pulse lasts more than one system clock cycle.
- R6: At most WORD_W bits per word are forwarded; slots beyond the word length produce no clock pulses, so words framed in 16 to 32 slots per channel all deliver exactly WORD_W pulses before their strobe.
- R7: After reset, no clock pulse or strobe appears until the first WS change seen on a BCK rising edge; the word whose MSB follows that change is the first one delivered.
- R8: While the asynchronous active-low reset is asserted, all six outputs are low.
- R9: Counting system clock edges from the first edge that samples a new BCK level as edge 1: after a BCK rise, the owning channel's data output changes at edge 3 and its clock output rises at edge 4; after a BCK fall, channel clocks fall and latch strobes update at edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the I2S bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bck_in | input | 1 | I2S bit clock, asynchronous to clk |
| ws_in | input | 1 | I2S word select, 0 = left, 1 = right |
| sd_in | input | 1 | I2S serial data, two's complement, MSB first |
| left_clk | output | 1 | Left channel burst clock |
| left_data | output | 1 | Left channel serial data, offset binary |
| left_latch | output | 1 | Left channel latch strobe |
| right_clk | output | 1 | Right channel burst clock |
| right_data | output | 1 | Right channel serial data, offset binary |
| right_latch | output | 1 | Right channel latch strobe |

## Verification
The stream is driven with frames of 16, 24 and 32 slots per channel, so a design that counts slots instead of bits, or forwards trailing slots, shows a wrong pulse count or a late strobe. Sample values at the extremes (all zeros, only the sign bit, the largest positive and negative values) separate an MSB-only inversion from a full inversion or none at all, and mixed patterns expose bit-order and channel-swap faults. A leading run of constant WS with busy data checks that nothing leaves before the first word boundary, and a reset in the middle of a word checks that outputs clear at once and the stream restarts cleanly.

// File: rtl/i2ss_pkg.sv
package i2ss_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // One decoded bit slot, valid only in the cycle of a BCK rising event
  typedef struct packed {
    logic  valid;    // bit is to be forwarded
    chan_e chan;     // owning channel (from WS one bit period earlier)
    logic  bit_val;  // data bit, MSB already inverted
    logic  last;     // this is bit index WORD_W-1 of the word
  } slot_t;

endpackage

// File: rtl/i2ss_sync.sv
module i2ss_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/i2ss_frame.sv
module i2ss_frame
  import i2ss_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bck_s,
  input  logic  ws_s,
  input  logic  sd_s,
  output logic  bck_rise,
  output logic  bck_fall,
  output slot_t slot
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic             ONE_BIT  = (WORD_W == 1);

  logic             bck_q;
  logic             primed_q, primed_n;
  logic             started_q, started_n;
  logic             ws_a_q, ws_a_n;   // WS at the previous BCK rise
  logic             ch_q, ch_n;       // WS one rise before that
  logic [CNT_W-1:0] cnt_q, cnt_n;     // bits already passed in this word
  logic             msb;
  logic             fwd;

  // Edge events and slot decode
  always_comb begin
    bck_rise     = bck_s & ~bck_q;
    bck_fall     = ~bck_s & bck_q;
    msb          = primed_q & (ws_a_q != ch_q);
    fwd          = primed_q & (msb | (started_q & (cnt_q < WORD_CNT)));
    slot.valid   = bck_rise & fwd;
    slot.chan    = chan_e'(ws_a_q);
    slot.bit_val = sd_s ^ msb;
    slot.last    = msb ? ONE_BIT : (cnt_q == LAST_IDX);
  end

  // Next state, enabled by the BCK rising event
  always_comb begin
    primed_n  = primed_q;
    started_n = started_q;
    ws_a_n    = ws_a_q;
    ch_n      = ch_q;
    cnt_n     = cnt_q;
    if (bck_rise) begin
      if (!primed_q) begin
        primed_n = 1'b1;
        ws_a_n   = ws_s;
        ch_n     = ws_s;
      end else begin
        ch_n   = ws_a_q;
        ws_a_n = ws_s;
        if (msb) begin
          started_n = 1'b1;
          cnt_n     = CNT_W'(1);
        end else if (cnt_q < WORD_CNT) begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q     <= 1'b0;
      primed_q  <= 1'b0;
      started_q <= 1'b0;
      ws_a_q    <= 1'b0;
      ch_q      <= 1'b0;
      cnt_q     <= '0;
    end else begin
      bck_q     <= bck_s;
      primed_q  <= primed_n;
      started_q <= started_n;
      ws_a_q    <= ws_a_n;
      ch_q      <= ch_n;
      cnt_q     <= cnt_n;
    end
  end

endmodule

// File: rtl/i2ss_lane.sv
module i2ss_lane
  import i2ss_pkg::*;
#(
  parameter chan_e LANE = CH_LEFT
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bck_fall,
  input  slot_t slot,
  output logic  lane_clk,
  output logic  lane_data,
  output logic  lane_latch
);

  logic data_q,  data_n;
  logic go_q,    go_n;     // clock rise one cycle after data update
  logic clk_q,   clk_n;
  logic pend_q,  pend_n;   // LSB taken, strobe due at next fall
  logic latch_q, latch_n;
  logic mine;

  always_comb begin
    mine    = slot.valid & (slot.chan == LANE);
    data_n  = data_q;
    go_n    = 1'b0;
    clk_n   = clk_q;
    pend_n  = pend_q;
    latch_n = latch_q;

    if (mine) begin
      data_n = slot.bit_val;
      go_n   = 1'b1;
      pend_n = slot.last;
    end

    if (go_q)          clk_n = 1'b1;
    else if (bck_fall) clk_n = 1'b0;

    if (bck_fall) begin
      latch_n = pend_q;
      pend_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      go_q    <= 1'b0;
      clk_q   <= 1'b0;
      pend_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      data_q  <= data_n;
      go_q    <= go_n;
      clk_q   <= clk_n;
      pend_q  <= pend_n;
      latch_q <= latch_n;
    end
  end

  assign lane_clk   = clk_q;
  assign lane_data  = data_q;
  assign lane_latch = latch_q;

endmodule

// File: rtl/i2s_simul_split.sv
module i2s_simul_split
  import i2ss_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic left_clk,
  output logic left_data,
  output logic left_latch,
  output logic right_clk,
  output logic right_data,
  output logic right_latch
);

  localparam int unsigned N_PINS  = 3;
  localparam int unsigned N_LANES = 2;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [N_PINS-1:0] pins_s;
  logic              bck_rise;
  logic              bck_fall;
  slot_t             slot;

  i2ss_sync #(
    .WIDTH  (N_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   ({sd_in, ws_in, bck_in}),
    .dout  (pins_s)
  );

  i2ss_frame #(
    .WORD_W (WORD_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bck_s    (pins_s[0]),
    .ws_s     (pins_s[1]),
    .sd_s     (pins_s[2]),
    .bck_rise (bck_rise),
    .bck_fall (bck_fall),
    .slot     (slot)
  );

  logic [N_LANES-1:0] lane_clk;
  logic [N_LANES-1:0] lane_dat;
  logic [N_LANES-1:0] lane_lat;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    i2ss_lane #(
      .LANE (chan_e'(1'(g)))
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .bck_fall   (bck_fall),
      .slot       (slot),
      .lane_clk   (lane_clk[g]),
      .lane_data  (lane_dat[g]),
      .lane_latch (lane_lat[g])
    );
  end

  assign left_clk    = lane_clk[CH_LEFT];
  assign left_data   = lane_dat[CH_LEFT];
  assign left_latch  = lane_lat[CH_LEFT];
  assign right_clk   = lane_clk[CH_RIGHT];
  assign right_data  = lane_dat[CH_RIGHT];
  assign right_latch = lane_lat[CH_RIGHT];

endmodule

// File: rtl/i2ss_checker.sv
module i2ss_checker (
  input logic clk,
  input logic rst_n,
  input logic left_clk,
  input logic left_data,
  input logic left_latch,
  input logic right_clk,
  input logic right_data,
  input logic right_latch
);

  AST_CLK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_clk && right_clk)); // R3

  AST_LEFT_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (left_clk && $past(left_clk)) |-> $stable(left_data)); // R5

  AST_RIGHT_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (right_clk && $past(right_clk)) |-> $stable(right_data)); // R5

  AST_LEFT_PULSE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(left_clk) |=> left_clk); // R5

  AST_RIGHT_PULSE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(right_clk) |=> right_clk); // R5

  AST_LEFT_LATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    left_latch |-> !left_clk); // R4

  AST_RIGHT_LATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    right_latch |-> !right_clk); // R4

  AST_LEFT_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(left_latch) |=> left_latch); // R4

  AST_RIGHT_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(right_latch) |=> right_latch); // R4

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!left_clk && !left_data && !left_latch &&
                               !right_clk && !right_data && !right_latch); // R8
    end
  end

endmodule

bind i2s_simul_split i2ss_checker u_i2ss_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .left_clk    (left_clk),
  .left_data   (left_data),
  .left_latch  (left_latch),
  .right_clk   (right_clk),
  .right_data  (right_data),
  .right_latch (right_latch)
);

// File: tb/i2s_simul_split_bench.sv
module i2s_simul_split_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int H          = 4;    // BCK half period in system clocks
  localparam int WD_LIMIT   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic left_clk, left_data, left_latch, right_clk, right_data, right_latch;

  i2s_simul_split #(.WORD_W(W)) u_i2s_simul_split (
    .clk(clk), .rst_n(rst_n), .bck_in(bck), .ws_in(ws), .sd_in(sd),
    .left_clk(left_clk), .left_data(left_data), .left_latch(left_latch),
    .right_clk(right_clk), .right_data(right_data), .right_latch(right_latch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  chk_en = 1'b0;
  bit  done = 1'b0;

  // Timed expectation ring: bit order lclk,ldata,llatch,rclk,rdata,rlatch
  logic [5:0] ring_m [64];
  logic [5:0] ring_v [64];
  logic [5:0] exp_o;
  logic [5:0] prev_act;

  // Behavioural model state
  int  k;
  bit  wm1, wm2, started;
  int  mcnt;
  bit  pend [2];

  // Port-level word observation
  logic [W-1:0] expq_l[$], expq_r[$];
  logic [W-1:0] sh_l, sh_r;
  int pc_l, pc_r, tot_pulses, tot_latches;

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, expv);
    end
  endtask

  task automatic sched(int n, int b, bit v);
    ring_m[n % 64][b] = 1'b1;
    ring_v[n % 64][b] = v;
  endtask

  always @(posedge clk) begin
    int ix;
    cyc++;
    ix = cyc % 64;
    exp_o = (exp_o & ~ring_m[ix]) | (ring_v[ix] & ring_m[ix]);
    ring_m[ix] = '0;
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    logic [5:0] act;
    act = {right_latch, right_data, right_clk, left_latch, left_data, left_clk};
    if (chk_en) begin
      for (int b = 0; b < 6; b++) begin
        string tag;
        tag = (b % 3 == 0) ? "R3/R9" : (b % 3 == 1) ? "R1/R9" : "R4/R9";
        check(act[b] == exp_o[b], tag, $sformatf("output bit %0d", b), act[b], exp_o[b]);
      end
      // R5: data held while channel clock stays high
      if (act[0] && prev_act[0])
        check(act[1] == prev_act[1], "R5", "left data moved under clock", act[1], prev_act[1]);
      if (act[3] && prev_act[3])
        check(act[4] == prev_act[4], "R5", "right data moved under clock", act[4], prev_act[4]);
      // Word assembly from the ports
      if (act[0] && !prev_act[0]) begin sh_l = {sh_l[W-2:0], act[1]}; pc_l++; tot_pulses++; end
      if (act[3] && !prev_act[3]) begin sh_r = {sh_r[W-2:0], act[4]}; pc_r++; tot_pulses++; end
      if (act[2] && !prev_act[2]) begin
        tot_latches++;
        check(pc_l == W, "R6", "left pulses per word", pc_l, W);
        if (expq_l.size() == 0) check(1'b0, "R1", "unexpected left word", sh_l, 0);
        else begin
          logic [W-1:0] e;
          e = expq_l.pop_front();
          check(sh_l == e, "R1/R2", "left word", sh_l, e);
        end
        pc_l = 0;
      end
      if (act[5] && !prev_act[5]) begin
        tot_latches++;
        check(pc_r == W, "R6", "right pulses per word", pc_r, W);
        if (expq_r.size() == 0) check(1'b0, "R1", "unexpected right word", sh_r, 0);
        else begin
          logic [W-1:0] e;
          e = expq_r.pop_front();
          check(sh_r == e, "R1/R2", "right word", sh_r, e);
        end
        pc_r = 0;
      end
    end
    prev_act = act;
  end

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin ring_m[i] = '0; ring_v[i] = '0; end
    exp_o = '0; prev_act = '0;
    k = 0; wm1 = 0; wm2 = 0; started = 0; mcnt = 0;
    pend[0] = 0; pend[1] = 0;
    expq_l.delete(); expq_r.delete();
    sh_l = '0; sh_r = '0; pc_l = 0; pc_r = 0; tot_pulses = 0; tot_latches = 0;
  endtask

  // BCK fall: clocks drop, strobes follow pending LSB (R4, R9)
  task automatic model_fall(int n0);
    for (int c = 0; c < 2; c++) begin
      sched(n0 + 2, c*3 + 2, pend[c]);
      sched(n0 + 2, c*3, 1'b0);
      pend[c] = 1'b0;
    end
  endtask

  // BCK rise: owner is WS of the previous slot, MSB after a WS change (R2, R3, R6, R7)
  task automatic model_rise(int n1, bit w, bit d);
    if (k >= 1) begin
      int  ch, idx;
      bit  msb, fwd;
      ch  = wm1;
      msb = (k >= 2) && (wm1 != wm2);
      fwd = msb || (started && mcnt < W);
      if (fwd) begin
        idx = msb ? 0 : mcnt;
        sched(n1 + 2, ch*3 + 1, d ^ msb);
        sched(n1 + 3, ch*3, 1'b1);
        pend[ch] = (idx == W - 1);
        if (msb) begin started = 1; mcnt = 1; end
        else mcnt++;
      end
    end
    wm2 = wm1; wm1 = w; k++;
  endtask

  task automatic send_slot(bit w, bit d);
    @(negedge clk);
    bck = 1'b0; ws = w; sd = d;
    model_fall(cyc + 1);
    repeat (H) @(negedge clk);
    bck = 1'b1;
    model_rise(cyc + 1, w, d);
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic send_half(bit c, logic [W-1:0] word, int slots);
    if (c) expq_r.push_back(word ^ {1'b1, {(W-1){1'b0}}});
    else   expq_l.push_back(word ^ {1'b1, {(W-1){1'b0}}});
    for (int j = 0; j < slots; j++)
      send_slot((j == slots - 1) ? ~c : c, (j < W) ? word[W-1-j] : 1'b1);
  endtask

  task automatic send_frame(logic [W-1:0] lw, logic [W-1:0] rw, int slots);
    send_half(1'b0, lw, slots);
    send_half(1'b1, rw, slots);
  endtask

  task automatic prelude();
    for (int i = 0; i < 3; i++) send_slot(1'b1, 1'b1);
    send_slot(1'b0, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bck = 1'b0; ws = 1'b0; sd = 1'b0; chk_en = 1'b0;
    @(negedge clk);
    // R8: outputs low while reset is held
    check(!left_clk && !right_clk, "R8", "clocks in reset", {left_clk, right_clk}, 0);
    check(!left_data && !right_data, "R8", "data in reset", {left_data, right_data}, 0);
    check(!left_latch && !right_latch, "R8", "strobes in reset", {left_latch, right_latch}, 0);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;
  endtask

  task automatic end_phase(string name);
    send_slot(1'b0, 1'b0);
    send_slot(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(expq_l.size() == 0, "R1", {name, " left words pending"}, expq_l.size(), 0);
    check(expq_r.size() == 0, "R1", {name, " right words pending"}, expq_r.size(), 0);
  endtask

  initial begin
    model_reset();

    // Phase 1: 16 slots per channel, extreme and mixed samples
    do_reset();
    prelude();
    check(tot_pulses == 0, "R7", "pulses before first word", tot_pulses, 0);
    check(tot_latches == 0, "R7", "strobes before first word", tot_latches, 0);
    send_frame(16'h0000, 16'h8000, 16);
    send_frame(16'h7FFF, 16'hFFFF, 16);
    send_frame(16'h1234, 16'hA5C3, 16);
    send_frame(16'h0001, 16'hFFFE, 16);
    end_phase("p1");
    check(tot_latches == 8, "R4", "strobe count 16-slot", tot_latches, 8);

    // Phase 2: 32 slots per channel, trailing slots suppressed, reset mid-word
    do_reset();
    prelude();
    send_frame(16'hC001, 16'h3FFE, 32);
    send_frame(16'h8001, 16'h7FFE, 32);
    send_frame(16'h5A5A, 16'h0F0F, 32);
    end_phase("p2");
    check(tot_pulses == 6 * W + 2, "R6", "total pulses 32-slot", tot_pulses, 6 * W + 2);
    for (int j = 0; j < 8; j++) send_slot(1'b0, 1'b1);
    do_reset();

    // Phase 3: 24 slots per channel, pseudo-random samples
    prelude();
    for (int f = 0; f < 6; f++)
      send_frame(W'($urandom), W'($urandom), 24);
    end_phase("p3");
    check(tot_latches == 12, "R4", "strobe count 24-slot", tot_latches, 12);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule